// File: doc/BRIEF.md
# Multi-channel compare timer with clear-on-match shortcuts

The block is an up-counter that runs in an 8-bit or a 16-bit width and watches several compare channels. Each channel holds a compare value. When the counter steps onto that value, the channel sets a sticky event flag. A masked OR of the flags forms a single interrupt request. Software loads one compare value per cycle through a small write port. Start, stop and clear tasks are single-cycle pulses. A flag is acknowledged by a pulse on its clear line.

Any channel can be given a clear-on-match shortcut. While the counter rests on that channel's value, the next tick loads zero instead of incrementing, which makes the roll-over period shorter. A zero reached this way is not treated as an arrival, so a channel that compares against zero stays silent. A zero reached by natural wrap from all-ones does count as an arrival. To silence a channel without stopping the counter, software loads it with a value the counter never reaches.

Top module: `cmp_timer`

## Requirements
- R1: While running, the counter adds one on every clock. In 8-bit mode (`wide_mode`=0) it wraps from 0xFF to 0, and in 16-bit mode (`wide_mode`=1) from 0xFFFF to 0.
- R2: A channel's flag bit `evt[i]` goes high in the same cycle that `count` first shows that channel's compare value after an increment.
- R3: When the counter wraps naturally to zero, every channel whose compare value is zero raises its flag.
- R4: If the counter is running, and it equals the compare value of a channel whose `short_en[i]` is 1, the next clock loads zero in place of an increment.
- R5: A zero produced by a shortcut raises no flag, including for channels set to zero. Channels set from one up to the shortcut value still fire on each pass.
- R6: A channel whose compare value lies above the shortcut value never fires.
- R7: A flag stays high until its `evt_clr[i]` bit is pulsed. If a new arrival falls in the same cycle as that clear, the flag stays set.
- R8: A pulse on `task_start` or `task_stop` takes effect from the next clock, and stop wins if both are pulsed. While stopped, `count` holds its value and no flag is raised again, even when `count` rests on a compare value.
- R9: A pulse on `task_clear` sets `count` to zero on the next clock, whatever the run state. It raises no flag and does not change the run state.
- R10: `irq` is the registered OR of (`evt` AND `irq_en`), and it changes in the same cycle as the flags.
- R11: A write with `wr_en`=1 loads `wr_data` into the compare register picked by `wr_idx`. This can happen while the counter is running, and comparisons use the new value from the next cycle on. Each write changes one channel only.
- R12: In 8-bit mode only bits [7:0] of a compare value take part in the match, and bits [15:8] of `count` stay zero.
- R13: Synchronous reset leaves the counter at zero and stopped, all compare values at zero, and all flags and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 16-bit counting, 0 selects 8-bit |
| task_start | input | 1 | Pulse that starts counting |
| task_stop | input | 1 | Pulse that stops counting |
| task_clear | input | 1 | Pulse that sets the counter to zero |
| wr_en | input | 1 | Compare register write strobe |
| wr_idx | input | IDX_W (2) | Channel picked for the write |
| wr_data | input | CNT_W (16) | Compare value to write |
| short_en | input | NCH (4) | Clear-on-match enable for each channel |
| irq_en | input | NCH (4) | Interrupt enable for each channel |
| evt_clr | input | NCH (4) | Flag acknowledge pulses |
| count | output | CNT_W (16) | Counter value |
| evt | output | NCH (4) | Sticky compare flags |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the shortcut reload to zero and the arrival check for a channel set to zero. The bench provokes it by running a shortened period with channel 0 at zero, and judges that this flag never rises while a channel at one fires on every pass. The second pair is an acknowledge pulse and a new arrival on the same flag. The bench times the pulse one cycle before the counter lands on the compare value, and expects the flag still set afterwards. A behavioural model is compared with `count`, `evt` and `irq` on every clock, so any other overlap also shows up as a mismatch.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic {RUN_IDLE = 1'b0, RUN_ACTIVE = 1'b1} run_e;

  function automatic logic [15:0] width_mask(input logic wide, input int narrow_w);
    logic [15:0] m;
    for (int b = 0; b < 16; b++) m[b] = wide | (b < narrow_w);
    return m;
  endfunction
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_mode,
  input  logic             task_start,
  input  logic             task_stop,
  input  logic             task_clear,
  input  logic             short_hit,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d,
  output logic [CNT_W-1:0] mask,
  output logic             step,
  output logic             running
);
  run_e state_q;

  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = wide_mode | (b < NARROW_W);
  end

  assign running = (state_q == RUN_ACTIVE);
  assign step    = running && !task_clear && !short_hit;

  always_comb begin
    if (task_clear || (running && short_hit)) count_d = '0;
    else if (step)                            count_d = (count_q + 1'b1) & mask;
    else                                      count_d = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      state_q <= RUN_IDLE;
    end else begin
      count_q <= count_d;
      if (task_stop)       state_q <= RUN_IDLE;
      else if (task_start) state_q <= RUN_ACTIVE;
    end
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] count_d,
  input  logic             step,
  input  logic             short_en,
  input  logic             ack,
  output logic             short_hit,
  output logic             flag_q,
  output logic             flag_d
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cmp_m;
  logic             arrive;

  assign cmp_m     = cmp_q & mask;
  assign short_hit = short_en && ((count_q & mask) == cmp_m);
  assign arrive    = step && (count_d == cmp_m);
  assign flag_d    = (flag_q & ~ack) | arrive;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_hit) cmp_q <= wr_data;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int NCH      = 4,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_mode,
  input  logic             task_start,
  input  logic             task_stop,
  input  logic             task_clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [NCH-1:0]   short_en,
  input  logic [NCH-1:0]   irq_en,
  input  logic [NCH-1:0]   evt_clr,
  output logic [CNT_W-1:0] count,
  output logic [NCH-1:0]   evt,
  output logic             irq
);
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] mask;
  logic             step;
  logic             running;
  logic [NCH-1:0]   hit_vec;
  logic [NCH-1:0]   flag_d;
  logic             short_any;

  assign short_any = |hit_vec;

  cmp_timer_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .task_start(task_start), .task_stop(task_stop), .task_clear(task_clear),
    .short_hit(short_any), .count_q(count), .count_d(count_d),
    .mask(mask), .step(step), .running(running)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_hit(wr_en && (int'(wr_idx) == i)), .wr_data(wr_data),
      .mask(mask), .count_q(count), .count_d(count_d), .step(step),
      .short_en(short_en[i]), .ack(evt_clr[i]),
      .short_hit(hit_vec[i]), .flag_q(evt[i]), .flag_d(flag_d[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_d & irq_en);
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int NCH      = 4,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wide_mode,
  input logic             task_clear,
  input logic [NCH-1:0]   evt_clr,
  input logic [NCH-1:0]   irq_en,
  input logic [CNT_W-1:0] count,
  input logic [NCH-1:0]   evt,
  input logic             irq,
  input logic             running,
  input logic             short_any
);
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    task_clear |=> (count == '0));

  a_r9_clear_no_event: assert property (@(posedge clk) disable iff (rst)
    task_clear |=> ((evt & ~$past(evt)) == '0));

  a_r4_short_to_zero: assert property (@(posedge clk) disable iff (rst)
    (running && short_any) |=> (count == '0));

  a_r5_short_no_event: assert property (@(posedge clk) disable iff (rst)
    (running && short_any) |=> ((evt & ~$past(evt)) == '0));

  a_r8_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!running && !task_clear) |=> ((count == $past(count)) && ((evt & ~$past(evt)) == '0)));

  a_r10_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq == |(evt & $past(irq_en)));

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && !$stable(count)) |-> (count[CNT_W-1:NARROW_W] == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && !evt_clr[i]) |=> evt[i]);
  end
endmodule

bind cmp_timer cmp_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .task_clear(task_clear),
  .evt_clr(evt_clr), .irq_en(irq_en), .count(count), .evt(evt), .irq(irq),
  .running(running), .short_any(short_any)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0, task_start = 1'b0, task_stop = 1'b0, task_clear = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  short_en = '0, irq_en = '0, evt_clr = '0;
  logic [15:0] count;
  logic [3:0]  evt;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .task_start(task_start),
    .task_stop(task_stop), .task_clear(task_clear), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .short_en(short_en), .irq_en(irq_en), .evt_clr(evt_clr),
    .count(count), .evt(evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_cnt, m_cc[NCH];
  logic [3:0]  m_evt;
  logic        m_irq, m_run;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_evt = 0; m_irq = 0; m_run = 0;
      for (int i = 0; i < NCH; i++) m_cc[i] = 0;
    end else begin
      logic [15:0] msk, nc;
      logic [3:0]  setv;
      bit          hit;
      msk  = wide_mode ? 16'hFFFF : 16'h00FF;
      setv = 0;
      hit  = 0;
      for (int i = 0; i < NCH; i++)
        if (short_en[i] && ((m_cnt & msk) == (m_cc[i] & msk))) hit = 1;
      if (task_clear)       nc = 0;
      else if (m_run && hit) nc = 0;
      else if (m_run) begin
        nc = (m_cnt + 16'd1) & msk;
        for (int i = 0; i < NCH; i++) if (nc == (m_cc[i] & msk)) setv[i] = 1'b1;
      end else nc = m_cnt;
      m_evt = (m_evt & ~evt_clr) | setv;
      m_irq = |(m_evt & irq_en);
      if (task_stop)       m_run = 0;
      else if (task_start) m_run = 1;
      if (wr_en) m_cc[wr_idx] = wr_data;
      m_cnt = nc;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk("R1 count vs model", {16'd0, count}, {16'd0, m_cnt});
      chk("R2 evt vs model", {28'd0, evt}, {28'd0, m_evt});
      chk("R10 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx[1:0]; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_start(); @(negedge clk); task_start = 1; @(negedge clk); task_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); task_stop = 1;  @(negedge clk); task_stop = 0;  endtask
  task automatic pulse_clear(); @(negedge clk); task_clear = 1; @(negedge clk); task_clear = 0; endtask
  task automatic ack(input logic [3:0] m); @(negedge clk); evt_clr = m; @(negedge clk); evt_clr = 0; endtask

  task automatic wait_cnt(input logic [15:0] v);
    int n = 0;
    @(negedge clk);
    while (count !== v && n < 70000) begin @(negedge clk); n++; end
    if (count !== v) chk("R1 reach value", {16'd0, count}, {16'd0, v});
  endtask

  initial begin
    cyc(3);
    rst = 0;
    armed = 1;
    cyc(1);
    chk("R13 reset count", {16'd0, count}, 0);
    chk("R13 reset evt", {28'd0, evt}, 0);
    chk("R13 reset irq", {31'd0, irq}, 0);

    // 8-bit free run: natural wrap, narrow compare
    wr(0, 16'h0000); wr(1, 16'h0105); wr(3, 16'h0080);
    pulse_start();
    cyc(20);
    chk("R12 low-bit match fires", {31'd0, evt[1]}, 1);
    chk("R3 zero not yet reached", {31'd0, evt[0]}, 0);
    begin
      bit saw_wrap = 0, upper_bad = 0;
      logic [15:0] prev = count;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (count[15:8] != 0) upper_bad = 1;
        if (prev == 16'h00FF && count == 0) saw_wrap = 1;
        prev = count;
      end
      chk("R1 8-bit wrap FF->0", {31'd0, saw_wrap}, 1);
      chk("R12 upper bits zero", {31'd0, upper_bad}, 0);
    end
    chk("R3 overflow fires zero channel", {31'd0, evt[0]}, 1);
    chk("R2 channel at 0x80 fired", {31'd0, evt[3]}, 1);

    // Collision: acknowledge in the arrival cycle
    ack(4'hF);
    wait_cnt(16'h0004);
    evt_clr = 4'b0010;
    @(negedge clk); evt_clr = 0;
    chk("R7 set wins over clear", {31'd0, evt[1]}, 1);
    ack(4'b0010);
    chk("R7 acknowledge clears", {31'd0, evt[1]}, 0);

    // Interrupt masking
    irq_en = 4'b0010;
    wait_cnt(16'h0006);
    chk("R10 enabled flag raises irq", {31'd0, irq}, 1);
    irq_en = 4'b0000;
    cyc(1);
    chk("R10 disabled irq low", {31'd0, irq}, 0);
    chk("R10 flag kept while masked", {31'd0, evt[1]}, 1);

    // Stop exactly on a compare value
    ack(4'hF);
    wait_cnt(16'h007F);
    task_stop = 1;
    @(negedge clk); task_stop = 0;
    chk("R8 lands on compare value", {16'd0, count}, 16'h0080);
    chk("R8 arrival flagged", {31'd0, evt[3]}, 1);
    ack(4'b1000);
    cyc(10);
    chk("R8 count held while stopped", {16'd0, count}, 16'h0080);
    chk("R8 no repeat event while resting", {31'd0, evt[3]}, 0);

    // Clear task while running
    pulse_start();
    cyc(5);
    ack(4'hF);
    @(negedge clk); task_clear = 1;
    @(negedge clk); task_clear = 0;
    chk("R9 clear forces zero", {16'd0, count}, 0);
    chk("R9 clear raises no event", {31'd0, evt[0]}, 0);
    cyc(3);
    chk("R9 still running after clear", {31'd0, (count != 0)}, 1);

    // Shortcut period
    pulse_stop(); pulse_clear(); ack(4'hF);
    wr(0, 16'h0000); wr(1, 16'h0001); wr(2, 16'h0040); wr(3, 16'h0041);
    short_en = 4'b0100;
    pulse_start();
    begin
      logic [15:0] mx = 0;
      int ones = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (count > mx) mx = count;
        if (evt[1]) begin ones++; evt_clr = 4'b0010; end else evt_clr = 0;
      end
      evt_clr = 0;
      chk("R4 period capped at shortcut value", {16'd0, mx}, 16'h0040);
      chk("R5 channel at one fires each pass", {31'd0, (ones >= 5)}, 1);
    end
    chk("R5 zero channel silent after shortcut", {31'd0, evt[0]}, 0);
    chk("R6 unreachable channel silent", {31'd0, evt[3]}, 0);
    wr(3, 16'h0030);
    cyc(100);
    chk("R11 rewrite while running takes effect", {31'd0, evt[3]}, 1);

    // 16-bit mode natural wrap
    pulse_stop(); pulse_clear();
    short_en = 0; wide_mode = 1;
    wr(0, 16'h0000); wr(1, 16'h0123);
    ack(4'hF);
    pulse_start();
    wait_cnt(16'h0100);
    chk("R1 16-bit passes 0xFF", {16'd0, count}, 16'h0100);
    chk("R3 no zero event before wrap", {31'd0, evt[0]}, 0);
    cyc(65600);
    chk("R3 16-bit wrap fires zero channel", {31'd0, evt[0]}, 1);
    chk("R2 16-bit compare fires", {31'd0, evt[1]}, 1);

    armed = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule